// File: doc/BRIEF.md
# Dual-Channel Half-Band 2x Interpolator

This block doubles the sample rate of a complex (I/Q) stream ahead of a CIC up-sampler. It applies a fixed seven-tap half-band low-pass kernel. Every other tap of that kernel is zero and its middle tap is exactly one. The kernel is evaluated in polyphase form, so all arithmetic runs once per input sample rather than once per output sample. For every accepted input pair the block emits two output pairs.

The first output of each pair is the interpolated point. It is a symmetric four-tap weighted sum of the four most recent inputs. The second output is the previous input passed through unchanged, which keeps it aligned with the group delay of the first. I and Q use identical logic side by side.

A small controller steps through three states:
- `S_IDLE` accepts a sample when `in_valid` is high and moves to `S_INTERP` (transition *accept*).
- `S_INTERP` loads the interpolated result into the output registers and moves to `S_CENTRE` (transition *emit-first*).
- `S_CENTRE` loads the delayed sample and returns to `S_IDLE` (transition *emit-second*).

Without `in_valid`, `S_IDLE` stays where it is (transition *wait*).

Top module: `hb2x_interp`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, both data outputs are 0, and the four-sample history of each channel is all zero.
- R2: `in_ready` is high only in `S_IDLE`. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly the next two cycles.
- R3: After the edge that takes a sample, `out_valid` is low for one cycle, then high for exactly two consecutive cycles. It is never high for three cycles in a row.
- R4: In the first valid cycle each channel outputs the interpolated point. Let x0 be the newest accepted sample and x3 the oldest of the last four. The point is (-3039*(x0+x3) + 19208*(x1+x2)) / 32768. The two constants are the outer and inner kernel taps quantised to signed Q1.15.
- R5: In the second valid cycle each channel outputs x1, the sample accepted just before the newest one.
- R6: The interpolated sum is rounded by adding 16384 and then shifting right arithmetically by 15 bits. This rounds to nearest, with exact halves going toward plus infinity.
- R7: Every output is saturated to the signed range [-2^(OUT_W-1), 2^(OUT_W-1)-1].
- R8: The I and Q channels use the same kernel and the same timing, with no interaction between them.
- R9: While `in_ready` is low, `in_valid` and the input data are ignored. The sample history does not change.
- R10: While `out_valid` is low, `out_i` and `out_q` keep the last values they emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_i | input | IN_W | In-phase input, signed |
| in_q | input | IN_W | Quadrature input, signed |
| out_valid | output | 1 | Output pair valid |
| out_i | output | OUT_W | In-phase output, signed |
| out_q | output | OUT_W | Quadrature output, signed |

## Verification
A controller stuck in the wrong state shows up at the ports within three cycles of a sample being taken. The symptoms are a missing or stretched `out_valid` pair, or `in_ready` rising too early. A corrupted or unshifted history register shows up within one input period. The first output of the next pair departs from the kernel sum, or the second output no longer equals the previously accepted sample. A mismatch in rounding or clamping shows only in the data values, so the bench compares every output cycle against a behavioural model. It drives impulse, constant, full-scale alternating and random streams.

// File: rtl/hb2x_pkg.sv
package hb2x_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_INTERP = 2'd1,
        S_CENTRE = 2'd2
    } hb_state_e;

    localparam int COEF_W = 16;
    localparam int FRAC   = COEF_W - 1;

    // Q1.15 quantised outer and inner taps of the half-band kernel
    localparam logic signed [COEF_W-1:0] K_OUTER = -16'sd3039;
    localparam logic signed [COEF_W-1:0] K_INNER =  16'sd19208;

    localparam int HIST = 4;

endpackage

// File: rtl/hb2x_ctrl.sv
module hb2x_ctrl
    import hb2x_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    output logic      in_ready,
    output logic      accept,
    output hb_state_e state,
    output logic      out_valid
);

    hb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:   if (in_valid) state_d = S_INTERP;
            S_INTERP: state_d = S_CENTRE;
            S_CENTRE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign in_ready = (state == S_IDLE);
    assign accept   = in_ready && in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= (state == S_INTERP) || (state == S_CENTRE);
    end

endmodule

// File: rtl/hb2x_taps.sv
module hb2x_taps #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift,
    input  logic [W-1:0]               din,
    output logic [DEPTH-1:0][W-1:0]    taps
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end

endmodule

// File: rtl/hb2x_sat.sv
module hb2x_sat #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  d,
    output logic signed [OUT_W-1:0] q
);

    generate
        if (IN_W <= OUT_W) begin : g_extend
            assign q = OUT_W'(d);
        end else begin : g_clamp
            localparam int HB = IN_W - OUT_W + 1;
            logic [HB-1:0] head;
            logic          ovf;
            assign head = d[IN_W-1:OUT_W-1];
            assign ovf  = !((&head) || !(|head));
            assign q = !ovf ? d[OUT_W-1:0]
                     : (d[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                  : {1'b0, {(OUT_W-1){1'b1}}});
        end
    endgenerate

endmodule

// File: rtl/hb2x_branch.sv
module hb2x_branch
    import hb2x_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  x0,
    input  logic signed [IN_W-1:0]  x1,
    input  logic signed [IN_W-1:0]  x2,
    input  logic signed [IN_W-1:0]  x3,
    output logic signed [OUT_W-1:0] y
);

    localparam int PAIR_W = IN_W + 1;
    localparam int ACC_W  = PAIR_W + COEF_W + 1;
    localparam int RND_W  = ACC_W - FRAC;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

    logic signed [PAIR_W-1:0] outer, inner;
    logic signed [ACC_W-1:0]  p_outer, p_inner, acc;
    logic signed [RND_W-1:0]  rnd;

    // fold symmetric taps before multiplying
    assign outer   = PAIR_W'(x0) + PAIR_W'(x3);
    assign inner   = PAIR_W'(x1) + PAIR_W'(x2);
    assign p_outer = ACC_W'(outer) * ACC_W'(K_OUTER);
    assign p_inner = ACC_W'(inner) * ACC_W'(K_INNER);
    assign acc     = p_outer + p_inner + HALF;
    assign rnd     = acc[ACC_W-1:FRAC];

    hb2x_sat #(.IN_W(RND_W), .OUT_W(OUT_W)) u_sat (.d(rnd), .q(y));

endmodule

// File: rtl/hb2x_interp.sv
module hb2x_interp
    import hb2x_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int NCH = 2;

    hb_state_e                     state;
    logic                          accept;
    logic [NCH-1:0][IN_W-1:0]      din;
    logic [NCH-1:0][OUT_W-1:0]     dout;

    assign din = {in_q, in_i};

    hb2x_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .state     (state),
        .out_valid (out_valid)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic [HIST-1:0][IN_W-1:0] taps;
            logic signed [OUT_W-1:0]   y_interp, y_centre, r_out;

            hb2x_taps #(.W(IN_W), .DEPTH(HIST)) u_taps (
                .clk   (clk),
                .rst_n (rst_n),
                .shift (accept),
                .din   (din[ch]),
                .taps  (taps)
            );

            hb2x_branch #(.IN_W(IN_W), .OUT_W(OUT_W)) u_branch (
                .x0 ($signed(taps[0])),
                .x1 ($signed(taps[1])),
                .x2 ($signed(taps[2])),
                .x3 ($signed(taps[3])),
                .y  (y_interp)
            );

            hb2x_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_centre (
                .d ($signed(taps[1])),
                .q (y_centre)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_out <= '0;
                end else begin
                    unique case (state)
                        S_INTERP: r_out <= y_interp;
                        S_CENTRE: r_out <= y_centre;
                        default:  r_out <= r_out;
                    endcase
                end
            end

            assign dout[ch] = r_out;
        end
    endgenerate

    assign out_i = dout[0];
    assign out_q = dout[1];

endmodule

// File: rtl/hb2x_checker.sv
module hb2x_checker #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q
);

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r2_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 !in_ready);

    a_r3_quiet_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !out_valid);

    a_r3_first_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid);

    a_r3_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid);

    a_r3_no_triple: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind hb2x_interp hb2x_checker #(.OUT_W(OUT_W)) u_hb2x_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/hb2x_interp_bench.sv
module hb2x_interp_bench;

    localparam int IN_W  = 16;
    localparam int OUT_W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst_n;
    logic                    in_valid;
    logic signed [IN_W-1:0]  in_i, in_q;
    logic                    in_ready, out_valid;
    logic signed [OUT_W-1:0] out_i, out_q;

    hb2x_interp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_hb2x_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q)
    );

    int    errs = 0, checks = 0;
    bit    done = 0;
    int    ms = 0;
    longint hi[4], hq[4];
    bit    ev = 0;
    longint ei = 0, eq = 0;
    int    eph = 0;
    int    nacc = 0;
    string tag = "";

    function automatic longint m_sat(longint v);
        longint hi_lim = (longint'(1) <<< (OUT_W - 1)) - 1;
        longint lo_lim = -(longint'(1) <<< (OUT_W - 1));
        if (v > hi_lim) return hi_lim;
        if (v < lo_lim) return lo_lim;
        return v;
    endfunction

    function automatic longint m_interp(longint a, longint b, longint c, longint d);
        longint s = -3039 * (a + d) + 19208 * (b + c);
        return m_sat((s + 16384) >>> 15);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit v, longint di, longint dq);
        case (ms)
            0: begin
                ev = 0;
                if (v) begin
                    for (int k = 3; k > 0; k--) begin
                        hi[k] = hi[k-1];
                        hq[k] = hq[k-1];
                    end
                    hi[0] = di;
                    hq[0] = dq;
                    nacc++;
                    ms = 1;
                end
            end
            1: begin
                ev = 1; eph = 1;
                ei = m_interp(hi[0], hi[1], hi[2], hi[3]);
                eq = m_interp(hq[0], hq[1], hq[2], hq[3]);
                ms = 2;
            end
            default: begin
                ev = 1; eph = 2;
                ei = m_sat(hi[1]);
                eq = m_sat(hq[1]);
                ms = 0;
            end
        endcase
    endtask

    task automatic cycle(bit v, logic [IN_W-1:0] di, logic [IN_W-1:0] dq);
        string base;
        in_valid = v;
        in_i = di;
        in_q = dq;
        step(v, longint'($signed(di)), longint'($signed(dq)));
        @(negedge clk);
        check("R2", {tag, " in_ready"}, longint'(in_ready), longint'(ms == 0));
        check("R3", {tag, " out_valid"}, longint'(out_valid), longint'(ev));
        base = !ev ? "R10" : (eph == 1 ? "R4" : "R5");
        check(base, {tag, " out_i"}, longint'(out_i), ei);
        check("R8", {tag, " out_q ", base}, longint'(out_q), eq);
    endtask

    task automatic run_phase(int mode, int ncyc);
        int base_acc = nacc;
        for (int c = 0; c < ncyc; c++) begin
            int idx = nacc - base_acc;
            bit v;
            logic [IN_W-1:0] di, dq;
            case (mode)
                0: begin
                    v = 1'b1;
                    di = (idx == 0) ? 16'sd16384 : 16'sd0;
                    dq = (idx == 0) ? -16'sd16384 : 16'sd0;
                end
                1: begin
                    v = ($urandom % 3) != 0;
                    di = 16'sd10000;
                    dq = -16'sd7000;
                end
                2: begin
                    v = $urandom % 2;
                    di = 16'($urandom);
                    dq = 16'($urandom);
                end
                3: begin
                    v = 1'b1;
                    di = (idx % 4 == 0 || idx % 4 == 3) ? 16'h7fff : 16'h8000;
                    dq = (idx % 4 == 0 || idx % 4 == 3) ? 16'h8000 : 16'h7fff;
                end
                default: begin
                    v = 1'b1;
                    di = 16'(c * 4099);
                    dq = 16'(c * -2311);
                end
            endcase
            cycle(v, di, dq);
        end
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            hi[k] = 0;
            hq[k] = 0;
        end
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_i = '0;
        in_q = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "reset in_ready", longint'(in_ready), 1);
        check("R1", "reset out_valid", longint'(out_valid), 0);
        check("R1", "reset out_i", longint'(out_i), 0);
        check("R1", "reset out_q", longint'(out_q), 0);

        tag = "R4 impulse";     run_phase(0, 40);
        tag = "R4 dc";          run_phase(1, 200);
        tag = "R6 random";      run_phase(2, 2000);
        tag = "R7 saturation";  run_phase(3, 200);
        tag = "R9 busy";        run_phase(4, 200);
        tag = "R6 random tail"; run_phase(2, 400);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule